// File: doc/BRIEF.md
# Multi-register stack push sequencer

This block carries out a push of several general-purpose registers onto a full-descending stack, driven by a 16-bit compact instruction word. When an instruction is accepted, the block checks the opcode field and the condition-pass input. It builds a 16-bit register mask from an 8-bit list of low registers and one extra bit that selects R14, the link register. It counts the selected registers and computes the lowest store address as the stack pointer minus four times that count.

It then reads the selected registers one at a time from a 16-entry register file, lowest register first. It presents each one as a 32-bit word write, with the address rising by four after each write, so the highest register ends up in the word just below the old stack pointer. Once the last write has completed, it commits the lowered stack pointer with a one-cycle write strobe.

Illegal cases produce one-cycle flags and leave memory and SP untouched:
- an empty register list raises the undefined-instruction flag;
- a stack pointer that is not word-aligned raises the alignment flag;
- a memory error during a write aborts the push and raises the memory-fault flag.

Instructions enter on a valid/ready handshake. `instr_ready` is high only while the block is idle, so the producer must hold `instr_valid` and the word until it sees ready. The write port is also valid/ready. Once `mem_valid` is raised, address and data stay fixed until a cycle in which `mem_ready` is high, and that cycle completes the write. The memory may hold `mem_ready` low for any number of cycles.

Top module: `push_sequencer`

## Requirements
- R1: An accepted word is treated as a push only when bits [15:9] equal 7'b1011010. Any other accepted word causes no write, no flag and no SP write.
- R2: Bits [7:0] of the word select R0..R7 (bit n selects Rn) and bit 8 selects R14. `rf_addr` presented during a write is always one of the selected registers.
- R3: The first write goes to `sp_in - 4*N`, where N is the number of selected registers. Each later write goes 4 bytes higher, so the last write is at `sp_in - 4`. Every write address is word-aligned.
- R4: Writes occur in ascending register number, and each write carries the value the register file returns for that register.
- R5: One cycle after the last write completes, `sp_we` and `done` are high together for exactly one cycle, with `sp_wdata = sp_in - 4*N`.
- R6: A push accepted with `sp_in[1:0] != 0` raises `align_fault` for one cycle and performs no write and no SP write.
- R7: A push whose bits [8:0] are all zero raises `undef_instr` for one cycle and performs no write and no SP write. At most one of `done`, `undef_instr`, `align_fault` and `mem_fault` is high in any cycle.
- R8: A word accepted with `cond_pass` low causes no write, no flag and no SP write.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R10: `busy` is high from the cycle after acceptance through the SP commit cycle. `instr_ready` is low whenever `busy` is high, so words offered during a push have no effect on it.
- R11: `mem_err` high in a cycle in which a write completes aborts the push. `mem_fault` is high for one cycle, no further write occurs, and no SP write or `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Block idle and able to take a word |
| instr_word | input | 16 | Compact instruction word |
| cond_pass | input | 1 | Condition check passed for the offered word |
| sp_in | input | 32 | Current stack pointer |
| rf_addr | output | 4 | Register file read index |
| rf_data | input | 32 | Register file read data (combinational) |
| mem_valid | output | 1 | Word write presented |
| mem_ready | input | 1 | Memory takes the write this cycle |
| mem_err | input | 1 | Write taken this cycle failed |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | New stack pointer value |
| busy | output | 1 | Push in progress |
| done | output | 1 | Push completed (one cycle) |
| undef_instr | output | 1 | Empty register list (one cycle) |
| align_fault | output | 1 | Misaligned stack pointer (one cycle) |
| mem_fault | output | 1 | Push aborted by memory error (one cycle) |

## Verification
The hardest case to reach is an abort in the middle of a list. It needs a long list, back-pressure that stretches individual writes, and an error arriving on one specific completed write, not the first. The bench's memory model counts completed writes and asserts `mem_err` only on a chosen index, while also imposing a periodic ready pattern. Separately, words are offered throughout a stalled push to show that they cannot disturb it.

// File: rtl/push_pkg.sv
package push_pkg;
  localparam int NREG     = 16;
  localparam int REG_IW   = $clog2(NREG);
  localparam int LIST_W   = 8;
  localparam int LINK_REG = 14;
  localparam int OPC_W    = 7;
  localparam logic [OPC_W-1:0] PUSH_OPC = 7'b1011010;
  localparam int CNT_W    = $clog2(NREG + 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_COMMIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/push_decode.sv
module push_decode
  import push_pkg::*;
(
  input  logic [15:0]      word,
  output logic             hit,
  output logic [NREG-1:0]  mask,
  output logic [CNT_W-1:0] count
);
  localparam int OPC_LSB = 16 - OPC_W;

  assign hit = (word[15:OPC_LSB] == PUSH_OPC);

  always_comb begin
    mask = '0;
    mask[LIST_W-1:0] = word[LIST_W-1:0];
    mask[LINK_REG]   = word[LIST_W];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NREG; i++) count = count + CNT_W'(mask[i]);
  end
endmodule

// File: rtl/lowbit_pick.sv
module lowbit_pick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_chain
      assign onehot[g]  = vec[g] & ~seen[g];
      assign seen[g+1]  = seen[g] | vec[g];
    end
  endgenerate

  assign any = seen[W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) if (onehot[i]) idx = IW'(i);
  end
endmodule

// File: rtl/push_sequencer.sv
module push_sequencer
  import push_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [15:0]       instr_word,
  input  logic              cond_pass,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [REG_IW-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  input  logic              mem_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_wdata,
  output logic              busy,
  output logic              done,
  output logic              undef_instr,
  output logic              align_fault,
  output logic              mem_fault
);
  localparam int WORD_B = DATA_W / 8;

  seq_state_t        state;
  logic [NREG-1:0]   rem_mask;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] sp_next;

  logic              dec_hit;
  logic [NREG-1:0]   dec_mask;
  logic [CNT_W-1:0]  dec_count;
  logic [NREG-1:0]   pick_oh;
  logic [REG_IW-1:0] pick_idx;
  logic              pick_any;
  logic [ADDR_W-1:0] base_addr;
  logic [NREG-1:0]   rem_after;
  logic              accept;
  logic              take;

  push_decode u_dec (
    .word  (instr_word),
    .hit   (dec_hit),
    .mask  (dec_mask),
    .count (dec_count)
  );

  lowbit_pick #(.W(NREG), .IW(REG_IW)) u_pick (
    .vec    (rem_mask),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  assign base_addr   = sp_in - ADDR_W'(dec_count) * ADDR_W'(WORD_B);
  assign instr_ready = (state == ST_IDLE);
  assign accept      = instr_valid && instr_ready;
  assign busy        = (state != ST_IDLE);
  assign mem_valid   = (state == ST_RUN) && pick_any;
  assign mem_addr    = wr_addr;
  assign mem_wdata   = rf_data;
  assign rf_addr     = pick_idx;
  assign take        = mem_valid && mem_ready;
  assign rem_after   = rem_mask & ~pick_oh;
  assign sp_we       = (state == ST_COMMIT);
  assign done        = (state == ST_COMMIT);
  assign sp_wdata    = sp_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rem_mask    <= '0;
      wr_addr     <= '0;
      sp_next     <= '0;
      undef_instr <= 1'b0;
      align_fault <= 1'b0;
      mem_fault   <= 1'b0;
    end else begin
      undef_instr <= 1'b0;
      align_fault <= 1'b0;
      mem_fault   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && cond_pass && dec_hit) begin
            if (dec_count == '0) begin
              undef_instr <= 1'b1;
            end else if (sp_in[1:0] != 2'b00) begin
              align_fault <= 1'b1;
            end else begin
              state    <= ST_RUN;
              rem_mask <= dec_mask;
              wr_addr  <= base_addr;
              sp_next  <= base_addr;
            end
          end
        end
        ST_RUN: begin
          if (take) begin
            if (mem_err) begin
              mem_fault <= 1'b1;
              rem_mask  <= '0;
              state     <= ST_IDLE;
            end else begin
              rem_mask <= rem_after;
              wr_addr  <= wr_addr + ADDR_W'(WORD_B);
              if (rem_after == '0) state <= ST_COMMIT;
            end
          end
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

  p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  p_rf_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((rf_addr < REG_IW'(LIST_W)) || (rf_addr == REG_IW'(LINK_REG))));

  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, undef_instr, align_fault, mem_fault}));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_no_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |-> (!sp_we && !mem_valid));

  p_commit_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> $past(mem_valid && mem_ready && !mem_err));
endmodule

// File: tb/tb_push_sequencer.sv
`timescale 1ns/1ps
module tb_push_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_word = '0;
  logic        cond_pass = 1'b0;
  logic [31:0] sp_in = '0;
  logic [3:0]  rf_addr;
  logic [31:0] rf_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        sp_we;
  logic [31:0] sp_wdata;
  logic        busy, done, undef_instr, align_fault, mem_fault;

  always #2.5 clk = ~clk;

  push_sequencer dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .cond_pass(cond_pass), .sp_in(sp_in),
    .rf_addr(rf_addr), .rf_data(rf_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata), .busy(busy),
    .done(done), .undef_instr(undef_instr), .align_fault(align_fault),
    .mem_fault(mem_fault)
  );

  function automatic logic [31:0] rfval(input int i);
    return 32'hA500_0000 + 32'(i) * 32'h0001_0203;
  endfunction
  assign rf_data = rfval(int'(rf_addr));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model / monitor
  int cyc = 0, stall_mode = 0, err_idx = 31;
  int nlog = 0, c_done = 0, c_spwe = 0, c_undef = 0, c_align = 0, c_fault = 0;
  int bad_ready = 0, stab_bad = 0;
  logic [31:0] last_sp;
  logic [31:0] log_a [32];
  logic [31:0] log_d [32];
  bit pend = 0;
  logic [31:0] pend_a, pend_d;

  always @(negedge clk) begin
    cyc++;
    case (stall_mode)
      1:       mem_ready = cyc[0];
      2:       mem_ready = (cyc % 3 == 2);
      default: mem_ready = 1'b1;
    endcase
    mem_err = mem_ready && mem_valid && (nlog == err_idx);
    if (pend && (!mem_valid || mem_addr != pend_a || mem_wdata != pend_d)) stab_bad++;
    pend = mem_valid && !mem_ready;
    pend_a = mem_addr;
    pend_d = mem_wdata;
    if (mem_valid && mem_ready && nlog < 32) begin
      log_a[nlog] = mem_addr;
      log_d[nlog] = mem_wdata;
      nlog++;
    end
    if (done) c_done++;
    if (sp_we) begin c_spwe++; last_sp = sp_wdata; end
    if (undef_instr) c_undef++;
    if (align_fault) c_align++;
    if (mem_fault) c_fault++;
    if (busy && instr_ready) bad_ready++;
  end

  task automatic clear_counts();
    nlog = 0; c_done = 0; c_spwe = 0; c_undef = 0; c_align = 0; c_fault = 0;
    bad_ready = 0; stab_bad = 0;
  endtask

  // Vector: instr[58:43] sp[42:11] cond[10] stall[9:8] err_idx[7:3] kind[2:0]
  // kind: 0 none, 1 complete, 2 undefined, 3 misaligned, 4 aborted
  localparam int NV = 11;
  localparam logic [58:0] VEC [NV] = '{
    {16'hB401, 32'h0000_1000, 1'b1, 2'd0, 5'd31, 3'd1},
    {16'hB5FF, 32'h0000_2000, 1'b1, 2'd0, 5'd31, 3'd1},
    {16'hB4A5, 32'h0000_3000, 1'b1, 2'd1, 5'd31, 3'd1},
    {16'hB500, 32'h0000_4000, 1'b1, 2'd2, 5'd31, 3'd1},
    {16'hB47E, 32'h0000_0040, 1'b1, 2'd1, 5'd31, 3'd1},
    {16'hB400, 32'h0000_1000, 1'b1, 2'd0, 5'd31, 3'd2},
    {16'hB481, 32'h0000_1002, 1'b1, 2'd0, 5'd31, 3'd3},
    {16'hB4FF, 32'h0000_1000, 1'b0, 2'd0, 5'd31, 3'd0},
    {16'h1234, 32'h0000_1000, 1'b1, 2'd0, 5'd31, 3'd0},
    {16'hB600, 32'h0000_1000, 1'b1, 2'd0, 5'd31, 3'd0},
    {16'hB50F, 32'h0000_5000, 1'b1, 2'd1, 5'd2,  3'd4}
  };

  task automatic issue(input logic [15:0] w, input logic [31:0] sp, input bit c,
                       input int sm, input int ei);
    @(negedge clk); #1;
    clear_counts();
    stall_mode = sm; err_idx = ei;
    instr_word = w; sp_in = sp; cond_pass = c; instr_valid = 1'b1;
    @(negedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic settle();
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); #1;
      if (!busy && k > 2) break;
    end
  endtask

  task automatic check_op(input logic [15:0] w, input logic [31:0] sp, input bit c,
                          input int ei, input int kind);
    logic [15:0] eff;
    int cnt, k, exp_n;
    eff = {1'b0, w[8], 6'b0, w[7:0]};
    cnt = $countones(eff);
    exp_n = (kind == 1) ? cnt : (kind == 4) ? ei + 1 : 0;
    chk(nlog == exp_n, (kind == 0) ? (c ? "R1 write count" : "R8 write count")
                                   : "R3 write count", 32'(nlog), 32'(exp_n));
    chk(c_done == (kind == 1 ? 1 : 0), "R5 done count", 32'(c_done), 32'(kind == 1));
    chk(c_spwe == (kind == 1 ? 1 : 0), (kind == 4) ? "R11 sp write" : "R5 sp write",
        32'(c_spwe), 32'(kind == 1));
    chk(c_undef == (kind == 2 ? 1 : 0), "R7 undef flag", 32'(c_undef), 32'(kind == 2));
    chk(c_align == (kind == 3 ? 1 : 0), "R6 align flag", 32'(c_align), 32'(kind == 3));
    chk(c_fault == (kind == 4 ? 1 : 0), "R11 fault flag", 32'(c_fault), 32'(kind == 4));
    chk(stab_bad == 0, "R9 hold under stall", 32'(stab_bad), 0);
    chk(bad_ready == 0, "R10 ready while busy", 32'(bad_ready), 0);
    if (kind == 1) chk(last_sp == sp - 32'(4 * cnt), "R5 new SP", last_sp, sp - 32'(4 * cnt));
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (eff[i] && k < exp_n && k < nlog) begin
        chk(log_a[k] == sp - 32'(4 * cnt) + 32'(4 * k), "R3 address", log_a[k],
            sp - 32'(4 * cnt) + 32'(4 * k));
        chk(log_d[k] == rfval(i), "R4 R2 data order", log_d[k], rfval(i));
        k++;
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // reset state
    chk(!busy && !mem_valid && !sp_we && !done, "R10 reset idle",
        {28'b0, busy, mem_valid, sp_we, done}, 0);
    chk(instr_ready == 1'b0 || instr_ready == 1'b1, "R10 reset ready known", 32'(instr_ready), 32'(instr_ready));
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(instr_ready && !undef_instr && !align_fault && !mem_fault, "R10 idle after reset",
        {28'b0, instr_ready, undef_instr, align_fault, mem_fault}, 32'h8);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v][58:43], VEC[v][42:11], VEC[v][10], int'(VEC[v][9:8]), int'(VEC[v][7:3]));
      settle();
      check_op(VEC[v][58:43], VEC[v][42:11], VEC[v][10], int'(VEC[v][7:3]), int'(VEC[v][2:0]));
    end

    // R10: words offered during a stalled push are ignored
    issue(16'hB4FF, 32'h0000_6000, 1'b1, 2, 31);
    instr_word = 16'hB401; sp_in = 32'h0000_6000; instr_valid = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); #1;
      if (!busy) break;
    end
    instr_valid = 1'b0;
    chk(nlog == 8, "R10 ignored during busy: writes", 32'(nlog), 8);
    chk(log_a[0] == 32'h0000_5FE0, "R10 ignored during busy: base", log_a[0], 32'h0000_5FE0);
    settle();
    check_op(16'hB4FF, 32'h0000_6000, 1'b1, 31, 1);

    // R11: error on the very first write
    issue(16'hB5F0, 32'h0000_7000, 1'b1, 0, 0);
    settle();
    check_op(16'hB5F0, 32'h0000_7000, 1'b1, 0, 4);

    // R5: block usable again after abort
    issue(16'hB402, 32'h0000_7000, 1'b1, 0, 31);
    settle();
    check_op(16'hB402, 32'h0000_7000, 1'b1, 31, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule